// File: doc/BRIEF.md
# Windowed Service Watchdog

This block supervises software by running a counter that must be cleared at regular intervals. Software clears it by writing a two-byte key to a service register. If the counter reaches the terminal value it has been set to, the block raises a one-cycle reset request for the system reset controller. It also sets a sticky flag that records the watchdog as the cause of the reset.

A configuration byte selects three things. The first is the step source: a slow tick-enable input or every core clock. The second is whether window mode is on. The third is one of three parameterised timeout lengths, or off. The first write to the configuration byte after reset loads all fields and locks them until the next reset. In window mode, software must service the watchdog only in the final quarter of the period. A write to the service register before that point is treated as a fault and requests a reset.

Both registers share one simple write port: an enable, an address and a data byte. The configuration register sits at address 0 and the service register at address 1.

Top module: `wdog_window_top`

## Requirements
- R1: The configuration byte at address 0 uses bit 0 for the step source, bit 1 for window mode and bits 3:2 for the timeout select. The first write after reset loads all three fields. Every later configuration write is ignored until reset.
- R2: With step source 0, the counter advances only in cycles where `tick_en` is high. With step source 1, it advances every clock cycle.
- R3: Timeout select 0 disables the watchdog: no counting and no reset request. Selects 1, 2 and 3 give periods of TERM_A, TERM_B and TERM_C steps (64, 256 and 1024 by default).
- R4: A service is a write of 0x55 to address 1 followed by a write of 0xAA to address 1. Any other byte written to address 1 restarts the sequence. In normal mode this causes no reset request.
- R5: A completed service clears the counter to zero, so the next expiry comes a full period later.
- R6: When a step brings the counter to the terminal value, `rst_req` is high for exactly the following cycle.
- R7: In window mode, any write to address 1 while the count is below `term - term/4` raises `rst_req` in the next cycle.
- R8: In window mode, a key sequence whose writes fall at a count of at least `term - term/4` is a valid service and raises no request.
- R9: `wdog_cause` is set together with every reset request and stays set until `rst_n` is asserted.
- R10: After reset, the step source is 0, window mode is off, the timeout select is 3, the lock is clear and both outputs are low.
- R11: If a valid service completes in the same cycle as the expiring step, the service wins and no request is raised.
- R12: After a reset request, the counter restarts from zero and runs a full period again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low system reset |
| tick_en | input | 1 | Slow tick enable, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0 configuration, 1 service) |
| wr_data | input | 8 | Write data byte |
| rst_req | output | 1 | One-cycle reset request |
| wdog_cause | output | 1 | Sticky watchdog reset cause |

## Verification
Service completion and counter expiry can both happen at the same clock edge. The bench provokes this by placing the 0xAA write exactly at the step where the count reaches the terminal value minus one. It then judges the outcome by checking that no request appears and that the next expiry arrives a full period later. A second collision sits at the window edge: a write at count `open-1` must fault, while one at `open` must not, and the bench places writes on each side of that boundary.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [KEY_W-1:0] KEY_FIRE = 8'hAA;

  // bit order matches the configuration byte: [3:2] tsel, [1] win, [0] src
  typedef struct packed {
    logic [1:0] tsel;
    logic       win;
    logic       src;
  } wdog_cfg_t;

  localparam int unsigned CFG_W = $bits(wdog_cfg_t);

  function automatic int unsigned pick_term(input logic [1:0] sel,
                                            input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
    case (sel)
      2'd1:    return a;
      2'd2:    return b;
      2'd3:    return c;
      default: return 0;
    endcase
  endfunction

  // first count that lies inside the final quarter
  function automatic int unsigned window_start(input int unsigned term);
    return term - (term / 4);
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter logic [1:0] RST_TSEL = 2'd3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  wdog_cfg_t cfg_in,
  output wdog_cfg_t cfg_q,
  output logic      locked
);

  logic cfg_take;
  assign cfg_take = cfg_we & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.tsel <= RST_TSEL;
      cfg_q.win  <= 1'b0;
      cfg_q.src  <= 1'b0;
      locked     <= 1'b0;
    end else if (cfg_take) begin
      cfg_q  <= cfg_in;
      locked <= 1'b1;
    end
  end

  // R1: once locked, no configuration field moves
  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_q));

  // R1: the first accepted write sets the lock
  assert_first_write_locks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> locked);

endmodule

// File: rtl/wdog_key.sv
module wdog_key
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_we,
  input  logic [KEY_W-1:0] svc_data,
  input  logic             abort,
  output logic             svc_ok
);

  logic armed;
  logic is_arm;
  logic is_fire;

  assign is_arm  = (svc_data == KEY_ARM);
  assign is_fire = (svc_data == KEY_FIRE);
  assign svc_ok  = svc_we & is_fire & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (abort)  armed <= 1'b0;
    else if (svc_we) armed <= is_arm;
  end

  // R4: a completed service consumes the armed state
  assert_fire_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> !armed);

  // R4: any byte other than the arm key leaves the sequence waiting for it
  assert_stray_byte_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_we && !is_arm) |=> !armed);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned TERM_A = 64,
  parameter int unsigned TERM_B = 256,
  parameter int unsigned TERM_C = 1024,
  parameter int unsigned CNT_W  = 11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  wdog_cfg_t cfg,
  input  logic      tick_en,
  input  logic      svc_we,
  input  logic      svc_ok,
  output logic      expire,
  output logic      early_hit
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] open_pt;
  logic             enabled;
  logic             step;
  logic             in_window;
  logic             svc_take;
  logic             at_end;

  assign term    = CNT_W'(pick_term(cfg.tsel, TERM_A, TERM_B, TERM_C));
  assign open_pt = CNT_W'(window_start(pick_term(cfg.tsel, TERM_A, TERM_B, TERM_C)));
  assign enabled = (cfg.tsel != 2'd0);
  assign step    = enabled & (cfg.src | tick_en);

  assign in_window = (cnt >= open_pt);
  assign at_end    = (cnt >= term - CNT_W'(1));

  // window fault outranks service; service outranks expiry
  assign early_hit = enabled & cfg.win & svc_we & ~in_window;
  assign svc_take  = svc_ok & ~early_hit;
  assign expire    = step & at_end & ~svc_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (early_hit | expire | svc_take) cnt <= '0;
    else if (step)                       cnt <= cnt + CNT_W'(1);
  end

  // R5: an accepted service leaves the count at zero
  assert_service_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_take |=> (cnt == '0));

  // R3: a disabled watchdog does not count
  assert_disabled_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !svc_ok) |=> $stable(cnt));

  // R12: a request restarts the period from zero
  assert_restart_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (expire || early_hit) |=> (cnt == '0));

  // R2: with the slow source selected, no tick means no movement
  assert_tick_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.src && !tick_en && !svc_ok && !svc_we) |=> $stable(cnt));

endmodule

// File: rtl/wdog_reqgen.sv
module wdog_reqgen (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic early_hit,
  output logic rst_req,
  output logic wdog_cause
);

  logic fire;
  assign fire = expire | early_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req    <= 1'b0;
      wdog_cause <= 1'b0;
    end else begin
      rst_req    <= fire;
      wdog_cause <= wdog_cause | fire;
    end
  end

  // R6, R7: every expiry or window fault becomes a request one cycle later
  assert_fire_to_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rst_req);

  // R6: no request without a cause in the previous cycle
  assert_no_spurious_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rst_req);

  // R9: the cause flag never drops outside reset
  assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_cause |=> wdog_cause);

endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 1,
  parameter int unsigned CFG_ADDR = 0,
  parameter int unsigned SVC_ADDR = 1,
  parameter int unsigned TERM_A   = 64,
  parameter int unsigned TERM_B   = 256,
  parameter int unsigned TERM_C   = 1024,
  parameter logic [1:0]  RST_TSEL = 2'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [KEY_W-1:0]  wr_data,
  output logic              rst_req,
  output logic              wdog_cause
);

  localparam int unsigned TERM_MAX = max3(TERM_A, TERM_B, TERM_C);
  localparam int unsigned CNT_W    = $clog2(TERM_MAX + 1);

  logic                   cfg_we;
  logic                   svc_we;
  logic                   svc_ok;
  logic                   expire;
  logic                   early_hit;
  logic                   locked;
  wdog_cfg_t              cfg_in;
  wdog_cfg_t              cfg_q;
  logic [KEY_W-CFG_W-1:0] unused_cfg_hi;

  assign cfg_we        = wr_en & (wr_addr == ADDR_W'(CFG_ADDR));
  assign svc_we        = wr_en & (wr_addr == ADDR_W'(SVC_ADDR));
  assign cfg_in        = wr_data[CFG_W-1:0];
  assign unused_cfg_hi = wr_data[KEY_W-1:CFG_W];

  wdog_cfg #(.RST_TSEL(RST_TSEL)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q),
    .locked (locked)
  );

  wdog_key u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_we   (svc_we),
    .svc_data (wr_data),
    .abort    (expire | early_hit),
    .svc_ok   (svc_ok)
  );

  wdog_counter #(
    .TERM_A (TERM_A),
    .TERM_B (TERM_B),
    .TERM_C (TERM_C),
    .CNT_W  (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg_q),
    .tick_en   (tick_en),
    .svc_we    (svc_we),
    .svc_ok    (svc_ok),
    .expire    (expire),
    .early_hit (early_hit)
  );

  wdog_reqgen u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .early_hit  (early_hit),
    .rst_req    (rst_req),
    .wdog_cause (wdog_cause)
  );

  // R9: a request is always accompanied by the cause flag
  assert_req_sets_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> wdog_cause);

  // R1: a write to a locked configuration cannot change it
  assert_locked_write_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && locked) |=> $stable(cfg_q));

endmodule

// File: tb/tb_wdog_window_top.sv
`timescale 1ns/1ps
module tb_wdog_window_top;

  localparam int TA = 64;
  localparam int TB = 256;
  localparam int TC = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rst_req;
  logic       wdog_cause;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdog_window_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rst_req    (rst_req),
    .wdog_cause (wdog_cause)
  );

  // {src, win, tsel[1:0], expected steps to request (0 = never)}
  localparam int NV = 5;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd1, 16'd64},
    {1'b1, 1'b0, 2'd2, 16'd256},
    {1'b1, 1'b0, 2'd3, 16'd1024},
    {1'b1, 1'b1, 2'd1, 16'd64},
    {1'b1, 1'b0, 2'd0, 16'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] cfg_byte(input logic src, input logic win, input logic [1:0] ts);
    return {4'b0000, ts, win, src};
  endfunction

  task automatic wait_req(input int limit, output int n);
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (rst_req) begin n = k; return; end
    end
  endtask

  int got;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    do_reset();
    chk("R10", "rst_req after reset", rst_req, 0);
    chk("R10", "cause after reset", wdog_cause, 0);
    repeat (200) @(negedge clk);
    chk("R2", "no request without ticks", rst_req | wdog_cause, 0);

    // R2 R10: default select 3 on the slow tick
    got = 0;
    for (int k = 1; k <= TC + 10; k++) begin
      tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
      if (rst_req) begin got = k; break; end
      @(negedge clk);
    end
    chk("R2", "ticks to default expiry", got, TC);
    @(negedge clk);
    chk("R6", "request lasts one cycle", rst_req, 0);
    repeat (5) @(negedge clk);
    chk("R9", "cause stays set", wdog_cause, 1);
    do_reset();
    chk("R9", "cause cleared by reset", wdog_cause, 0);

    // R3 R6: table of timeout lengths
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(1'b0, cfg_byte(VEC[i][19], VEC[i][18], VEC[i][17:16]));
      wait_req(TC + 200, got);
      chk("R3", $sformatf("steps to request, vector %0d", i), got, int'(VEC[i][15:0]));
    end

    // R12: second period after a request
    do_reset();
    wr(1'b0, cfg_byte(1'b1, 1'b0, 2'd1));
    wait_req(200, got);
    wait_req(200, got);
    chk("R12", "second period length", got, TA);

    // R7: window fault one count before the window opens
    do_reset();
    wr(1'b0, cfg_byte(1'b1, 1'b1, 2'd1));
    repeat (TA - TA/4 - 1) @(negedge clk);
    wr(1'b1, 8'h55);
    chk("R7", "early write requests reset", rst_req, 1);
    chk("R7", "early write sets cause", wdog_cause, 1);
    @(negedge clk);
    chk("R6", "fault request one cycle", rst_req, 0);

    // R8 R5: service exactly at window opening
    do_reset();
    wr(1'b0, cfg_byte(1'b1, 1'b1, 2'd1));
    repeat (TA - TA/4) @(negedge clk);
    wr(1'b1, 8'h55);
    chk("R8", "arm write in window", rst_req, 0);
    wr(1'b1, 8'hAA);
    chk("R8", "fire write in window", rst_req, 0);
    wait_req(200, got);
    chk("R5", "full period after late service", got, TA);

    // R11: service coincides with the expiring step
    do_reset();
    wr(1'b0, cfg_byte(1'b1, 1'b1, 2'd1));
    repeat (TA - 2) @(negedge clk);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
    chk("R11", "service beats expiry", rst_req | wdog_cause, 0);
    wait_req(200, got);
    chk("R11", "period after collision", got, TA);

    // R4: stray byte mid-sequence, normal mode
    do_reset();
    wr(1'b0, cfg_byte(1'b1, 1'b0, 2'd1));
    wr(1'b1, 8'h55);
    wr(1'b1, 8'h12);
    wr(1'b1, 8'hAA);
    chk("R4", "stray byte gives no request", rst_req, 0);
    wait_req(200, got);
    chk("R4", "stray byte voids service", got, TA - 3);

    // R5: early service fine in normal mode
    do_reset();
    wr(1'b0, cfg_byte(1'b1, 1'b0, 2'd1));
    repeat (10) @(negedge clk);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
    chk("R5", "normal early service no request", rst_req, 0);
    wait_req(200, got);
    chk("R5", "full period after service", got, TA);

    // R1: second configuration write ignored
    do_reset();
    wr(1'b0, cfg_byte(1'b1, 1'b0, 2'd1));
    wr(1'b0, cfg_byte(1'b1, 1'b1, 2'd3));
    wr(1'b1, 8'h55);
    chk("R1", "window bit not taken", rst_req, 0);
    wait_req(TC + 100, got);
    chk("R1", "timeout select not taken", got, TA - 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule